// File: doc/BRIEF.md
# Per-CPU Interrupt Presenter

This unit sits between an interrupt source fabric and a single processor. It takes one pending external request (a 24-bit vector with an 8-bit priority), keeps a current processor priority byte and an inter-processor interrupt (IPI) priority byte, and drives one interrupt line to the processor. A lower priority number is more favoured. The line is raised only when a pending request is strictly more favoured than the current processor priority.

Software reaches the unit through a small word-addressed register port with a valid strobe, a write flag, byte enables and registered read data. The request word puts the processor priority in bits 31:24 and the vector in bits 23:0. Reading the accepting view takes the interrupt and raises the processor priority to the priority of that interrupt. Writing the full word back ends the interrupt and loads the processor priority from the top byte. The poll view gives the same word with no side effects. A separate IPI byte produces vector 2 at the priority that is written into it.

Top module: `cpu_irq_presenter`

## Requirements
- R1: A read of offset 0x0 or 0x4 returns, in the cycle after the request, a word with the processor priority from before the access in bits 31:24 and the presented vector in bits 23:0.
- R2: When no pending request is strictly more favoured than the processor priority, the vector field reads as 0, and a read of offset 0x4 changes nothing.
- R3: A write to offset 0xC with byte enable 3 set loads the IPI priority from wdata[31:24]. Any value other than 0xFF makes vector 2 pending at that priority. 0xFF withdraws it. A write to 0xC without byte enable 3 is ignored.
- R4: A read of offset 0x4 while a request is presented sets the processor priority to the priority of that request. If the request is external, src_ack_o pulses for one cycle together with the read data.
- R5: cpu_irq_o is high exactly when the external request (src_valid_i high) or the IPI has a priority numerically below the processor priority. A processor priority of 0xFF passes any priority below 0xFF. A processor priority of 0 blocks everything.
- R6: The more favoured of the external request and the IPI is presented. When their priorities are equal, the IPI (vector 2) is presented.
- R7: A write to offset 0x4 with all four byte enables is an end-of-interrupt. It loads the processor priority from wdata[31:24], and in the next cycle it pulses eoi_valid_o with eoi_vec_o = wdata[23:0].
- R8: A write to offset 0x4 with only byte enable 3 loads the processor priority from wdata[31:24] and produces no eoi_valid_o pulse.
- R9: A read of offset 0x0 changes neither the processor priority nor the pending state, so repeated polls return the same word.
- R10: After reset the processor priority is 0x00, the IPI priority is 0xFF, and cpu_irq_o, src_ack_o and eoi_valid_o are low.
- R11: A read of offset 0xC returns the IPI priority in bits 31:24 and zeros below it. Offset 0x8 reads as zero and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_valid_i | input | 1 | External request pending |
| src_vec_i | input | 24 | External request vector |
| src_prio_i | input | 8 | External request priority |
| src_ack_o | output | 1 | One-cycle pulse: external request accepted |
| eoi_valid_o | output | 1 | One-cycle pulse: end-of-interrupt written |
| eoi_vec_o | output | 24 | Vector completed by the last end-of-interrupt |
| bus_valid_i | input | 1 | Register access strobe |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 4 | Byte offset (bits 3:2 select the word) |
| bus_be_i | input | 4 | Byte enables, bit 3 = bits 31:24 |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data |
| bus_rvalid_o | output | 1 | Read data valid, one cycle after a read |
| cpu_irq_o | output | 1 | Interrupt line to the processor |

## Verification
The assertions assume at most one register access per cycle. They also assume that the source keeps its vector and priority stable while src_valid_i is high, and that it drops the request once src_ack_o has pulsed, before any further accepting read. The stimulus changes every input on the falling clock edge and issues accesses one at a time. It withdraws the external request right after each acknowledged accept, so the interrupt-line check, which reads the source inputs directly, always compares against a settled request.

// File: rtl/cip_pkg.sv
package cip_pkg;

  // Word slot selected by bus address bits 3:2.
  typedef enum logic [1:0] {
    SLOT_POLL   = 2'd0,
    SLOT_ACCEPT = 2'd1,
    SLOT_RSVD   = 2'd2,
    SLOT_IPI    = 2'd3
  } slot_e;

  // Which source won arbitration.
  typedef enum logic [1:0] {
    WIN_NONE = 2'd0,
    WIN_EXT  = 2'd1,
    WIN_IPI  = 2'd2
  } win_e;

endpackage

// File: rtl/cip_decode.sv
module cip_decode
  import cip_pkg::*;
#(
  parameter int unsigned VEC_W  = 24,
  parameter int unsigned PRIO_W = 8
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              bus_valid_i,
  input  logic                              bus_write_i,
  input  logic [3:0]                        bus_addr_i,
  input  logic [(VEC_W+PRIO_W)/8-1:0]       bus_be_i,
  input  logic [VEC_W+PRIO_W-1:0]           bus_wdata_i,
  output logic                              rd_en_o,
  output slot_e                             rd_slot_o,
  output logic                              wr_cppr_o,
  output logic                              wr_eoi_o,
  output logic                              wr_ipi_o,
  output logic [PRIO_W-1:0]                 wr_prio_o,
  output logic [VEC_W-1:0]                  wr_vec_o
);

  localparam int unsigned DATA_W = VEC_W + PRIO_W;
  localparam int unsigned LANES  = DATA_W / 8;
  localparam int unsigned TOP    = LANES - 1;
  localparam logic [LANES-1:0] TOP_ONLY = {1'b1, {(LANES-1){1'b0}}};
  localparam logic [LANES-1:0] ALL_ON   = {LANES{1'b1}};

  slot_e slot;
  logic  wr_access;

  assign slot      = slot_e'(bus_addr_i[3:2]);
  assign wr_access = bus_valid_i & bus_write_i;

  always_comb begin
    rd_en_o   = bus_valid_i & ~bus_write_i;
    rd_slot_o = slot;
    wr_cppr_o = wr_access && (slot == SLOT_ACCEPT) && (bus_be_i == TOP_ONLY);
    wr_eoi_o  = wr_access && (slot == SLOT_ACCEPT) && (bus_be_i == ALL_ON);
    wr_ipi_o  = wr_access && (slot == SLOT_IPI) && bus_be_i[TOP];
    wr_prio_o = bus_wdata_i[DATA_W-1 -: PRIO_W];
    wr_vec_o  = bus_wdata_i[VEC_W-1:0];
  end

  // R8: a priority-only write and an end-of-interrupt never coincide
  assert_one_op_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_cppr_o, wr_eoi_o, wr_ipi_o}));

endmodule

// File: rtl/cip_arbiter.sv
module cip_arbiter
  import cip_pkg::*;
#(
  parameter int unsigned VEC_W        = 24,
  parameter int unsigned PRIO_W       = 8,
  parameter int unsigned IPI_VEC      = 2,
  parameter bit          IPI_WINS_TIE = 1'b1
) (
  input  logic              src_valid_i,
  input  logic [VEC_W-1:0]  src_vec_i,
  input  logic [PRIO_W-1:0] src_prio_i,
  input  logic [PRIO_W-1:0] ipi_prio_i,
  input  logic [PRIO_W-1:0] cppr_i,
  output logic              present_o,
  output win_e              win_o,
  output logic [VEC_W-1:0]  win_vec_o,
  output logic [PRIO_W-1:0] win_prio_o
);

  localparam logic [PRIO_W-1:0] PRIO_OFF = {PRIO_W{1'b1}};
  localparam logic [VEC_W-1:0]  IPI_CODE = VEC_W'(IPI_VEC);

  logic ipi_live;
  logic ipi_beats;
  logic ipi_first;

  assign ipi_live = (ipi_prio_i != PRIO_OFF);

  generate
    if (IPI_WINS_TIE) begin : g_tie_ipi
      assign ipi_beats = (ipi_prio_i <= src_prio_i);
    end else begin : g_tie_ext
      assign ipi_beats = (ipi_prio_i < src_prio_i);
    end
  endgenerate

  assign ipi_first = ipi_live && (!src_valid_i || ipi_beats);

  always_comb begin
    win_o      = WIN_NONE;
    win_vec_o  = '0;
    win_prio_o = PRIO_OFF;
    if (ipi_first) begin
      win_o      = WIN_IPI;
      win_vec_o  = IPI_CODE;
      win_prio_o = ipi_prio_i;
    end else if (src_valid_i) begin
      win_o      = WIN_EXT;
      win_vec_o  = src_vec_i;
      win_prio_o = src_prio_i;
    end
    present_o = (win_o != WIN_NONE) && (win_prio_o < cppr_i);
  end

endmodule

// File: rtl/cip_state.sv
module cip_state #(
  parameter int unsigned PRIO_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_cppr_i,
  input  logic              wr_eoi_i,
  input  logic              wr_ipi_i,
  input  logic [PRIO_W-1:0] wr_prio_i,
  input  logic              take_i,
  input  logic [PRIO_W-1:0] take_prio_i,
  output logic [PRIO_W-1:0] cppr_o,
  output logic [PRIO_W-1:0] ipi_prio_o
);

  logic [PRIO_W-1:0] cppr_q, cppr_d;
  logic              cppr_en;
  logic [PRIO_W-1:0] ipi_q, ipi_d;
  logic              ipi_en;

  always_comb begin
    cppr_en = 1'b0;
    cppr_d  = cppr_q;
    if (wr_eoi_i || wr_cppr_i) begin
      cppr_en = 1'b1;
      cppr_d  = wr_prio_i;
    end else if (take_i) begin
      cppr_en = 1'b1;
      cppr_d  = take_prio_i;
    end
    ipi_en = wr_ipi_i;
    ipi_d  = wr_prio_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cppr_q <= '0;
      ipi_q  <= '1;
    end else begin
      if (cppr_en) cppr_q <= cppr_d;
      if (ipi_en)  ipi_q  <= ipi_d;
    end
  end

  assign cppr_o     = cppr_q;
  assign ipi_prio_o = ipi_q;

  assert_accept_prio_R4: assert property (@(posedge clk) disable iff (!rst_n)
    take_i |=> cppr_o == $past(take_prio_i));

  assert_eoi_prio_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_eoi_i |=> cppr_o == $past(wr_prio_i));

endmodule

// File: rtl/cpu_irq_presenter.sv
module cpu_irq_presenter
  import cip_pkg::*;
#(
  parameter int unsigned VEC_W        = 24,
  parameter int unsigned PRIO_W       = 8,
  parameter int unsigned IPI_VEC      = 2,
  parameter bit          IPI_WINS_TIE = 1'b1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        src_valid_i,
  input  logic [VEC_W-1:0]            src_vec_i,
  input  logic [PRIO_W-1:0]           src_prio_i,
  output logic                        src_ack_o,
  output logic                        eoi_valid_o,
  output logic [VEC_W-1:0]            eoi_vec_o,
  input  logic                        bus_valid_i,
  input  logic                        bus_write_i,
  input  logic [3:0]                  bus_addr_i,
  input  logic [(VEC_W+PRIO_W)/8-1:0] bus_be_i,
  input  logic [VEC_W+PRIO_W-1:0]     bus_wdata_i,
  output logic [VEC_W+PRIO_W-1:0]     bus_rdata_o,
  output logic                        bus_rvalid_o,
  output logic                        cpu_irq_o
);

  localparam int unsigned DATA_W = VEC_W + PRIO_W;

  logic              rd_en, wr_cppr, wr_eoi, wr_ipi;
  slot_e             rd_slot;
  logic [PRIO_W-1:0] wr_prio;
  logic [VEC_W-1:0]  wr_vec;
  logic [PRIO_W-1:0] cppr, ipi_prio;
  logic              present;
  win_e              win;
  logic [VEC_W-1:0]  win_vec;
  logic [PRIO_W-1:0] win_prio;
  logic              take;

  cip_decode #(.VEC_W(VEC_W), .PRIO_W(PRIO_W)) u_decode (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_valid_i (bus_valid_i),
    .bus_write_i (bus_write_i),
    .bus_addr_i  (bus_addr_i),
    .bus_be_i    (bus_be_i),
    .bus_wdata_i (bus_wdata_i),
    .rd_en_o     (rd_en),
    .rd_slot_o   (rd_slot),
    .wr_cppr_o   (wr_cppr),
    .wr_eoi_o    (wr_eoi),
    .wr_ipi_o    (wr_ipi),
    .wr_prio_o   (wr_prio),
    .wr_vec_o    (wr_vec)
  );

  cip_arbiter #(
    .VEC_W(VEC_W), .PRIO_W(PRIO_W), .IPI_VEC(IPI_VEC), .IPI_WINS_TIE(IPI_WINS_TIE)
  ) u_arbiter (
    .src_valid_i (src_valid_i),
    .src_vec_i   (src_vec_i),
    .src_prio_i  (src_prio_i),
    .ipi_prio_i  (ipi_prio),
    .cppr_i      (cppr),
    .present_o   (present),
    .win_o       (win),
    .win_vec_o   (win_vec),
    .win_prio_o  (win_prio)
  );

  assign take = rd_en && (rd_slot == SLOT_ACCEPT) && present;

  cip_state #(.PRIO_W(PRIO_W)) u_state (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_cppr_i   (wr_cppr),
    .wr_eoi_i    (wr_eoi),
    .wr_ipi_i    (wr_ipi),
    .wr_prio_i   (wr_prio),
    .take_i      (take),
    .take_prio_i (win_prio),
    .cppr_o      (cppr),
    .ipi_prio_o  (ipi_prio)
  );

  // Output registers: next-state logic.
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic              rvalid_q, ack_q, ack_d;
  logic              eoi_q;
  logic [VEC_W-1:0]  eoi_vec_q;

  always_comb begin
    rdata_d = rdata_q;
    if (rd_en) begin
      unique case (rd_slot)
        SLOT_POLL, SLOT_ACCEPT: rdata_d = {cppr, present ? win_vec : {VEC_W{1'b0}}};
        SLOT_IPI:               rdata_d = {ipi_prio, {VEC_W{1'b0}}};
        default:                rdata_d = '0;
      endcase
    end
    ack_d = take && (win == WIN_EXT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q   <= '0;
      rvalid_q  <= 1'b0;
      ack_q     <= 1'b0;
      eoi_q     <= 1'b0;
      eoi_vec_q <= '0;
    end else begin
      if (rd_en) rdata_q <= rdata_d;
      rvalid_q <= rd_en;
      ack_q    <= ack_d;
      eoi_q    <= wr_eoi;
      if (wr_eoi) eoi_vec_q <= wr_vec;
    end
  end

  assign bus_rdata_o  = rdata_q;
  assign bus_rvalid_o = rvalid_q;
  assign src_ack_o    = ack_q;
  assign eoi_valid_o  = eoi_q;
  assign eoi_vec_o    = eoi_vec_q;
  assign cpu_irq_o    = present;

  assert_ack_with_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
    src_ack_o |-> bus_rvalid_o);

  assert_irq_exact_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq_o == ((src_valid_i && (src_prio_i < cppr)) || (ipi_prio < cppr)));

  assert_poll_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_slot == SLOT_POLL) |=> (cppr == $past(cppr)) && (ipi_prio == $past(ipi_prio)));

  assert_pulses_apart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({src_ack_o, eoi_valid_o}));

endmodule

// File: tb/cpu_irq_presenter_tb.sv
`timescale 1ns/1ps
module cpu_irq_presenter_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        src_valid;
  logic [23:0] src_vec;
  logic [7:0]  src_prio;
  logic        src_ack, eoi_valid;
  logic [23:0] eoi_vec;
  logic        bus_valid, bus_write;
  logic [3:0]  bus_addr;
  logic [3:0]  bus_be;
  logic [31:0] bus_wdata, bus_rdata;
  logic        bus_rvalid, cpu_irq;

  int n_chk  = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  cpu_irq_presenter dut_i (
    .clk(clk), .rst_n(rst_n),
    .src_valid_i(src_valid), .src_vec_i(src_vec), .src_prio_i(src_prio),
    .src_ack_o(src_ack), .eoi_valid_o(eoi_valid), .eoi_vec_o(eoi_vec),
    .bus_valid_i(bus_valid), .bus_write_i(bus_write), .bus_addr_i(bus_addr),
    .bus_be_i(bus_be), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .bus_rvalid_o(bus_rvalid), .cpu_irq_o(cpu_irq)
  );

  // {src_valid, src_prio, src_vec, ipi_prio, cppr, exp_irq, exp_vec}
  localparam logic [73:0] TBL [9] = '{
    {1'b1, 8'h05, 24'h000100, 8'hFF, 8'hFF, 1'b1, 24'h000100},
    {1'b1, 8'h05, 24'h000100, 8'h04, 8'hFF, 1'b1, 24'h000002},
    {1'b1, 8'h04, 24'h000100, 8'h04, 8'hFF, 1'b1, 24'h000002},
    {1'b1, 8'h03, 24'h0ABCDE, 8'h04, 8'hFF, 1'b1, 24'h0ABCDE},
    {1'b1, 8'h05, 24'h000100, 8'hFF, 8'h05, 1'b0, 24'h000000},
    {1'b1, 8'h05, 24'h000100, 8'hFF, 8'h06, 1'b1, 24'h000100},
    {1'b0, 8'h00, 24'h000000, 8'h07, 8'h00, 1'b0, 24'h000000},
    {1'b1, 8'hFF, 24'h000033, 8'hFF, 8'hFF, 1'b0, 24'h000000},
    {1'b0, 8'h00, 24'h000000, 8'hFF, 8'hFF, 1'b0, 24'h000000}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [3:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_be = be; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic bus_rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a; bus_be = 4'h0;
    @(negedge clk);
    bus_valid = 1'b0;
    d = bus_rdata;
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  initial begin
    logic [31:0] rd;
    logic [73:0] e;
    rst_n = 1'b0; src_valid = 1'b0; src_vec = '0; src_prio = '0;
    bus_valid = 1'b0; bus_write = 1'b0; bus_addr = '0; bus_be = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    check("R10 irq in reset", {31'b0, cpu_irq}, 32'd0);
    check("R10 pulses in reset", {30'b0, src_ack, eoi_valid}, 32'd0);
    rst_n = 1'b1;

    // R10: reset values of priority and IPI byte
    bus_rd(4'h0, rd); check("R10 poll after reset", rd, 32'h00000000);
    bus_rd(4'hC, rd); check("R10 R11 ipi after reset", rd, 32'hFF000000);

    // R5: priority 0 blocks a pending external request
    src_valid = 1'b1; src_prio = 8'h00; src_vec = 24'h000077; #2;
    check("R5 cppr 0 blocks", {31'b0, cpu_irq}, 32'd0);
    src_valid = 1'b0;

    // Table: arbitration and masking (R5, R6, R8, R1)
    for (int i = 0; i < 9; i++) begin
      e = TBL[i];
      bus_wr(4'h4, 4'b1000, {e[32:25], 24'h0});
      bus_wr(4'hC, 4'b1000, {e[40:33], 24'h0});
      src_valid = e[73]; src_prio = e[72:65]; src_vec = e[64:41]; #2;
      check($sformatf("R5 R6 irq row %0d", i), {31'b0, cpu_irq}, {31'b0, e[24]});
      bus_rd(4'h0, rd);
      check($sformatf("R1 R6 poll row %0d", i), rd, {e[32:25], e[23:0]});
    end
    src_valid = 1'b0;

    // R4: accept an external request
    src_valid = 1'b1; src_prio = 8'h05; src_vec = 24'h123456;
    bus_rd(4'h4, rd);
    check("R4 R1 accept data", rd, 32'hFF123456);
    check("R4 ack pulse", {31'b0, src_ack}, 32'd1);
    src_valid = 1'b0; #2;
    check("R4 irq drops", {31'b0, cpu_irq}, 32'd0);
    bus_rd(4'h0, rd); check("R4 priority raised", rd, 32'h05000000);
    check("R4 ack single cycle", {31'b0, src_ack}, 32'd0);

    // R2: accept with nothing presented
    bus_rd(4'h4, rd); check("R2 spurious accept", rd, 32'h05000000);
    check("R2 no ack", {31'b0, src_ack}, 32'd0);
    bus_rd(4'h0, rd); check("R2 no change", rd, 32'h05000000);

    // R7: end-of-interrupt
    bus_wr(4'h4, 4'b1111, 32'hFF123456);
    check("R7 eoi pulse", {31'b0, eoi_valid}, 32'd1);
    check("R7 eoi vector", {8'h0, eoi_vec}, 32'h00123456);
    bus_rd(4'h0, rd); check("R7 priority restored", rd, 32'hFF000000);

    // R8: priority-only write
    bus_wr(4'h4, 4'b1000, 32'h03AAAAAA);
    check("R8 no eoi", {31'b0, eoi_valid}, 32'd0);
    bus_rd(4'h0, rd); check("R8 priority only", rd, 32'h03000000);

    // R3 / R9: IPI raise, polling, accept, withdraw
    bus_wr(4'hC, 4'b1000, 32'h02000000); #2;
    check("R3 ipi raises irq", {31'b0, cpu_irq}, 32'd1);
    bus_rd(4'h0, rd); check("R9 poll ipi", rd, 32'h03000002);
    bus_rd(4'h0, rd); check("R9 poll repeat", rd, 32'h03000002);
    check("R9 irq kept", {31'b0, cpu_irq}, 32'd1);
    bus_rd(4'h4, rd); check("R3 accept ipi", rd, 32'h03000002);
    check("R3 no ack for ipi", {31'b0, src_ack}, 32'd0);
    check("R3 irq after accept", {31'b0, cpu_irq}, 32'd0);
    bus_rd(4'h0, rd); check("R4 priority from ipi", rd, 32'h02000000);
    bus_wr(4'h4, 4'b1111, 32'hFF000002); #2;
    check("R3 ipi still pending", {31'b0, cpu_irq}, 32'd1);
    bus_wr(4'hC, 4'b0111, 32'hFFFFFFFF); #2;
    check("R3 lane 3 needed", {31'b0, cpu_irq}, 32'd1);
    bus_wr(4'hC, 4'b1000, 32'hFF000000); #2;
    check("R3 ipi withdrawn", {31'b0, cpu_irq}, 32'd0);
    bus_rd(4'hC, rd); check("R11 ipi readback", rd, 32'hFF000000);

    // R11: reserved word
    bus_wr(4'h8, 4'b1111, 32'h01020304);
    bus_rd(4'h8, rd); check("R11 reserved reads zero", rd, 32'h00000000);
    bus_rd(4'h0, rd); check("R11 reserved write no effect", rd, 32'hFF000000);

    // R5: priority 0 blocks the IPI too
    bus_wr(4'h4, 4'b1000, 32'h00000000);
    bus_wr(4'hC, 4'b1000, 32'h00000000); #2;
    check("R5 cppr 0 blocks ipi", {31'b0, cpu_irq}, 32'd0);

    summary();
  end

endmodule